// File: doc/BRIEF.md
# Shared General-Purpose I/O Port with Peripheral Override

This block is one parallel I/O port of configurable width. Every bit has a direction register bit, an output latch bit and a read-only view of the sampled pin level, all reached through a small register interface. A peripheral can share each pin. When that peripheral is enabled and requests the pin's output, it takes both the output data and the output enable, and the port's own driver for that bit is switched off. The pin can still be read through the pin view.

The pad inputs pass through a two-stage synchronizer. The synchronized level feeds both the pin view and the peripheral's input data. The port keeps its own output off the peripheral's input: whenever the port drives a pin, the peripheral sees 0 on that bit. A mask parameter marks which bits exist. Missing bits read as zero, ignore writes and never enable their pad driver.

Top module: `gpio_shared_port`

## Requirements
- R1: A direction bit of 0 on a bit the peripheral does not own sets pad_oe to 1 and pad_out to the latch bit. A direction bit of 1 on such a bit sets pad_oe to 0.
- R2: After reset, the direction register reads IMPL_MASK (every implemented bit is an input), the latch reads 0 and pad_oe is 0.
- R3: A write to address 2 loads the latch in the next cycle, and a read at address 2 returns the latch.
- R4: A read at address 1 returns pin_in masked by IMPL_MASK, as sampled two clock edges earlier. A write to address 1 loads the latch and leaves that read value unchanged.
- R5: A bit with per_en=1 and per_oe=1 is owned by the peripheral: pad_oe=1, pad_out=per_out, and the address 1 read still shows the pin.
- R6: A bit with per_en=0, or with per_oe=0, is controlled by the direction and latch bits as in R1.
- R7: per_in of a bit is 0 whenever the port drives that bit (pad_oe=1 and the bit is not owned by the peripheral). Otherwise per_in is the synchronized pin level.
- R8: Bits that are 0 in IMPL_MASK read as 0 at addresses 0, 1 and 2, ignore writes, and keep pad_oe, pad_out and per_in at 0.
- R9: Address 0 reads and writes the direction register. Address 3 reads as 0 and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Single-cycle write strobe |
| reg_addr | input | 2 | Register select: 0 direction, 1 pin view, 2 latch, 3 none |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Combinational read data |
| pin_in | input | WIDTH | Levels at the pads |
| pad_out | output | WIDTH | Output data to the pads |
| pad_oe | output | WIDTH | Output enable to the pads |
| per_en | input | WIDTH | Peripheral enabled, per bit |
| per_oe | input | WIDTH | Peripheral requests the output, per bit |
| per_out | input | WIDTH | Peripheral output data, per bit |
| per_in | output | WIDTH | Input data delivered to the peripheral |

## Verification
The ownership mux is exercised with five vectors:
- All pins as inputs.
- All pins as outputs, with the peripheral requesting the output while disabled.
- A mix in which the peripheral owns some output bits and is enabled but idle on others.
- Split directions with a partial override.
- An enabled peripheral that drives nothing.

These vectors tell port ownership apart from peripheral ownership. They also separate "enabled" from "enabled and driving", and they show per_in blanked only where the port itself drives. Directed cases cover the following:
- The reset state.
- The two-edge synchronizer delay.
- A write to the pin view address landing in the latch.
- The masked top bit.
- The empty address.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  typedef enum logic [1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_PINS = 2'd1,
    ADDR_LAT  = 2'd2,
    ADDR_NONE = 2'd3
  } gsp_addr_e;
endpackage

// File: rtl/gsp_regs.sv
module gsp_regs
  import gsp_pkg::*;
#(
  parameter int unsigned       WIDTH     = 8,
  parameter logic [WIDTH-1:0]  IMPL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  gsp_addr_e        addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q
);
  localparam logic [WIDTH-1:0] DIR_RST = IMPL_MASK;

  logic dir_wr, lat_wr;
  assign dir_wr = we && (addr == ADDR_DIR);
  assign lat_wr = we && ((addr == ADDR_LAT) || (addr == ADDR_PINS));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RST;
      lat_q <= '0;
    end else begin
      if (dir_wr) dir_q <= wdata & IMPL_MASK;
      if (lat_wr) lat_q <= wdata & IMPL_MASK;
    end
  end

  a_r2_reset_inputs: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dir_q == IMPL_MASK && lat_q == '0));
  a_r3_lat_load: assert property (@(posedge clk) disable iff (rst)
    (we && (addr == ADDR_LAT || addr == ADDR_PINS)) |=> (lat_q == ($past(wdata) & IMPL_MASK)));
  a_r9_none_no_effect: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_NONE) |=> ($stable(dir_q) && $stable(lat_q)));
endmodule

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gsp_pinmux.sv
module gsp_pinmux #(
  parameter int unsigned      WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] per_en,
  input  logic [WIDTH-1:0] per_oe,
  input  logic [WIDTH-1:0] per_out,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] per_in
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam logic HERE = IMPL_MASK[i];
    logic own, port_drv;
    assign own      = HERE & per_en[i] & per_oe[i];
    assign port_drv = HERE & ~own & ~dir_q[i];
    always_comb begin
      pad_oe[i]  = own | port_drv;
      pad_out[i] = HERE & (own ? per_out[i] : lat_q[i]);
      per_in[i]  = HERE & ~port_drv & pin_sync[i];
    end

    a_r5_owner_drives: assert property (@(posedge clk) disable iff (rst)
      (HERE && per_en[i] && per_oe[i]) |-> (pad_oe[i] && pad_out[i] == per_out[i]));
    a_r7_no_loop: assert property (@(posedge clk) disable iff (rst)
      (pad_oe[i] && !(per_en[i] && per_oe[i])) |-> !per_in[i]);
  end

  a_r8_absent_quiet: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe | pad_out | per_in) & ~IMPL_MASK) == '0);
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
  import gsp_pkg::*;
#(
  parameter int unsigned      WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = 8'h7F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  input  logic [WIDTH-1:0] per_en,
  input  logic [WIDTH-1:0] per_oe,
  input  logic [WIDTH-1:0] per_out,
  output logic [WIDTH-1:0] per_in
);
  localparam int unsigned SYNC_STAGES = 2;

  gsp_addr_e        addr;
  logic [WIDTH-1:0] dir_q, lat_q, pin_sync, pin_view;

  assign addr     = gsp_addr_e'(reg_addr);
  assign pin_view = pin_sync & IMPL_MASK;

  gsp_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(addr), .wdata(reg_wdata),
    .dir_q(dir_q), .lat_q(lat_q)
  );

  gsp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gsp_pinmux #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_mux (
    .clk(clk), .rst(rst), .dir_q(dir_q), .lat_q(lat_q), .pin_sync(pin_sync),
    .per_en(per_en), .per_oe(per_oe), .per_out(per_out),
    .pad_out(pad_out), .pad_oe(pad_oe), .per_in(per_in)
  );

  always_comb begin
    case (addr)
      ADDR_DIR:  reg_rdata = dir_q;
      ADDR_PINS: reg_rdata = pin_view;
      ADDR_LAT:  reg_rdata = lat_q;
      default:   reg_rdata = '0;
    endcase
  end

  a_r9_none_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd3) |-> (reg_rdata == '0));
  a_r1_input_quiet: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd0 && !reg_we) |-> ((pad_oe & reg_rdata & ~(per_en & per_oe)) == '0));
endmodule

// File: tb/sim_gpio_shared_port.sv
`timescale 1ns/1ps
module sim_gpio_shared_port;
  localparam int W = 8;
  logic clk = 0, rst = 1, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [W-1:0] reg_wdata = 0, reg_rdata, pin_in = 0, pad_out, pad_oe;
  logic [W-1:0] per_en = 0, per_oe = 0, per_out = 0, per_in;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_shared_port #(.WIDTH(W), .IMPL_MASK(8'h7F)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .per_en(per_en), .per_oe(per_oe), .per_out(per_out), .per_in(per_in));

  // fields: dir, lat, pen, poe, pout, pin | exp_oe, exp_out, exp_per_in, exp_pins
  localparam logic [79:0] VEC [5] = '{
    80'hFF_00_00_00_00_A5_00_00_25_25,
    80'h00_5A_00_FF_FF_3C_7F_5A_00_3C,
    80'h00_0F_F0_30_10_FF_7F_1F_30_7F,
    80'hF0_AA_0F_03_01_00_0F_29_00_00,
    80'h0F_FF_FF_00_FF_C3_70_7F_03_43
  };

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd(2'd0, r); chk("R2 dir reset", r, 8'h7F);
    rd(2'd2, r); chk("R2 lat reset", r, 8'h00);
    chk("R2 oe reset", pad_oe, 8'h00);

    foreach (VEC[k]) begin
      logic [79:0] v = VEC[k];
      wr(2'd0, v[79:72]);
      wr(2'd2, v[71:64]);
      @(negedge clk);
      per_en = v[63:56]; per_oe = v[55:48]; per_out = v[47:40]; pin_in = v[39:32];
      repeat (3) @(negedge clk);
      chk("R1/R5/R6 pad_oe", pad_oe, v[31:24]);
      chk("R1/R5/R6 pad_out", pad_out, v[23:16]);
      chk("R7 per_in", per_in, v[15:8]);
      rd(2'd1, r); chk("R4/R5 pin view", r, v[7:0]);
    end

    per_en = 0; per_oe = 0;
    wr(2'd0, 8'hFF); rd(2'd0, r); chk("R8/R9 dir masked", r, 8'h7F);
    wr(2'd2, 8'hC6); rd(2'd2, r); chk("R3 lat readback", r, 8'h46);
    @(negedge clk); pin_in = 8'h81;
    repeat (2) @(negedge clk);
    rd(2'd1, r); chk("R8 pin view masked", r, 8'h01);
    wr(2'd1, 8'h33);
    rd(2'd2, r); chk("R4 pin write hits latch", r, 8'h33);
    rd(2'd1, r); chk("R4 pin view unchanged", r, 8'h01);
    @(negedge clk); pin_in = 8'h14;
    @(negedge clk);
    rd(2'd1, r); chk("R4 one edge old", r, 8'h01);
    @(negedge clk);
    rd(2'd1, r); chk("R4 two edges new", r, 8'h14);
    wr(2'd3, 8'h00);
    rd(2'd3, r); chk("R9 addr3 zero", r, 8'h00);
    rd(2'd0, r); chk("R9 addr3 write no effect", r, 8'h7F);
    wr(2'd0, 8'h00);
    @(negedge clk);
    chk("R1 all outputs", pad_oe, 8'h7F);
    chk("R8 absent bit quiet", pad_out & 8'h80, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule